// File: doc/BRIEF.md
# Banked UART Data and Interrupt-Enable Register Front End

This block sits between a CPU bus and the serial core of a UART that also offers infrared modes. It decodes a small banked 8-bit register space. One offset acts as the data port. A read there drains the receive side and a write there fills the transmit side. The port is backed either by a single holding register per direction or by a 16-entry FIFO per direction, chosen by a FIFO-enable bit. The block also holds the interrupt-enable register and produces the interrupt line from the enables and the pending source flags.

A DMA controller reaches the data port through two acknowledge strobes. These strobes work whatever bank is selected and take priority over a CPU access in the same cycle. The serial shifters are outside this block. They appear here as a receive-push stub and a transmit-pop stub.

The upper half of the interrupt-enable register depends on the operating mode. It can be written only in Extended mode. It reads zero and is cleared whenever Non-Extended mode is selected.

Top module: `uart_regfront`

## Requirements
- R1: After reset the bank select is 0, the mode register is 0 (holding registers, Non-Extended), the interrupt-enable register is 0, irqOut is 0, txEmpty is 1 and txOverrun is 0.
- R2: With FIFOs disabled (mode bit 0 = 0), a CPU read of offset 0 in bank 0 returns the byte most recently pushed by rxPush. A CPU write there loads txByte and clears txEmpty. txPop sets txEmpty again.
- R3: With FIFOs enabled (mode bit 0 = 1), reads of offset 0 return received bytes oldest first. Reading an empty receive FIFO returns the last byte read and pops nothing. The transmit FIFO holds 16 bytes and presents them on txByte in write order. A write to a full transmit FIFO is dropped and sets txOverrun.
- R4: Offset 3 is the bank select (bits 1:0) in every bank and reads back. Offsets 0 and 1 act only in bank 0. In other banks a CPU read there returns 0 and pops nothing, and a CPU write there changes nothing.
- R5: dmaRdAck pops the receive side and returns the byte on cpuRdata. dmaWrAck pushes cpuWdata to the transmit side. Both work in any bank.
- R6: In Non-Extended mode (mode bit 1 = 0), interrupt-enable bits 7:4 read 0 and a write stores only bits 3:0.
- R7: In Extended mode (mode bit 1 = 1), all 8 interrupt-enable bits (offset 1, bank 0) are writable and read back. Switching to Non-Extended clears bits 7:4.
- R8: irqOut is the OR over i of irqSrc[i] AND enable[i]. It follows irqSrc at once and reflects a new enable value right after the write's clock edge.
- R9: The mode register is offset 2 in bank 1 and reads back in bits 1:0. Any write to it empties both FIFOs, invalidates the transmit holding register and clears txOverrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | CPU access strobe, one cycle per access |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 2 | Register offset |
| cpuWdata | input | 8 | Write data for CPU and DMA writes |
| cpuRdata | output | 8 | Read data, valid in the access cycle |
| dmaRdAck | input | 1 | DMA read of the receive data port |
| dmaWrAck | input | 1 | DMA write of the transmit data port |
| rxPush | input | 1 | Receive stub delivers rxByte |
| rxByte | input | 8 | Received byte |
| txPop | input | 1 | Transmit stub consumes txByte |
| txByte | output | 8 | Next byte to transmit |
| txEmpty | output | 1 | Nothing waiting to transmit |
| txOverrun | output | 1 | Sticky: write to full transmit FIFO |
| irqSrc | input | 8 | Pending interrupt source flags |
| irqOut | output | 1 | Interrupt request |

## Verification
Read data and irqOut are combinational. The bench samples them 1 ns after driving, in the same cycle as the access. Register, FIFO and flag updates land at the access's rising edge, so txByte, txEmpty, txOverrun, the readback of a written register and the effect of a new enable on irqOut are sampled 1 ns after that edge. Before each check the bench leaves no access outstanding. Then a pop that should not have happened shows up as a wrong byte on the next read.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFF_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_MODE = 2'd2;
  localparam logic [ADDR_W-1:0] OFF_BANK = 2'd3;

  typedef struct packed {
    logic rxPop;
    logic txPush;
    logic flush;
    logic fifoEn;
  } dpStrobe_t;
endpackage

// File: rtl/uart_regfront_fifo.sv
module uart_regfront_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !flush) |=> $stable(count));
  p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> empty);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_regfront_ctrl.sv
module uart_regfront_ctrl
  import uart_regfront_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              dmaRdAck,
  input  logic              dmaWrAck,
  input  logic [DATA_W-1:0] irqSrc,
  input  logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              irqOut,
  output dpStrobe_t         strobe
);
  localparam int unsigned LO_W = DATA_W / 2;
  localparam int unsigned HI_W = DATA_W - LO_W;

  logic [1:0]        bankSel;
  logic              fifoEn, extMode;
  logic [DATA_W-1:0] ienReg;
  logic              dmaAny, cpuAcc, inBank0, inBank1;
  logic              ienWr, modeWr, bankWr;

  assign dmaAny  = dmaRdAck || dmaWrAck;
  assign cpuAcc  = cpuSel && !dmaAny;
  assign inBank0 = (bankSel == 2'd0);
  assign inBank1 = (bankSel == 2'd1);
  assign ienWr   = cpuAcc && cpuWr && inBank0 && (cpuAddr == OFF_IEN);
  assign modeWr  = cpuAcc && cpuWr && inBank1 && (cpuAddr == OFF_MODE);
  assign bankWr  = cpuAcc && cpuWr && (cpuAddr == OFF_BANK);

  always_comb begin
    strobe.rxPop  = dmaRdAck || (cpuAcc && !cpuWr && inBank0 && cpuAddr == OFF_DATA);
    strobe.txPush = dmaWrAck || (cpuAcc && cpuWr && inBank0 && cpuAddr == OFF_DATA);
    strobe.flush  = modeWr;
    strobe.fifoEn = fifoEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankSel <= '0;
      fifoEn  <= 1'b0;
      extMode <= 1'b0;
      ienReg  <= '0;
    end else begin
      if (bankWr) bankSel <= cpuWdata[1:0];
      if (modeWr) begin
        fifoEn  <= cpuWdata[0];
        extMode <= cpuWdata[1];
        if (!cpuWdata[1]) ienReg[DATA_W-1:LO_W] <= '0;
      end
      if (ienWr) begin
        ienReg[LO_W-1:0]      <= cpuWdata[LO_W-1:0];
        ienReg[DATA_W-1:LO_W] <= extMode ? cpuWdata[DATA_W-1:LO_W] : '0;
      end
    end
  end

  always_comb begin
    cpuRdata = '0;
    if (dmaRdAck) begin
      cpuRdata = rxData;
    end else if (cpuAcc && !cpuWr) begin
      case (cpuAddr)
        OFF_DATA: if (inBank0) cpuRdata = rxData;
        OFF_IEN:  if (inBank0) cpuRdata = ienReg;
        OFF_MODE: if (inBank1) cpuRdata = {{(DATA_W-2){1'b0}}, extMode, fifoEn};
        default:  cpuRdata = {{(DATA_W-2){1'b0}}, bankSel};
      endcase
    end
  end

  assign irqOut = |(ienReg & irqSrc);

  p_upper_masked_r6: assert property (@(posedge clk) disable iff (!rstN)
    !extMode |-> (ienReg[DATA_W-1:LO_W] == HI_W'(0)));
  p_dma_any_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaWrAck || dmaRdAck) |-> (strobe.txPush == dmaWrAck) || strobe.rxPop);
  p_bank_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaAny && !inBank0) |-> !strobe.rxPop && !strobe.txPush);
  p_ien_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ienWr && !modeWr) |=> $stable(ienReg));
endmodule

// File: rtl/uart_regfront_dp.sv
module uart_regfront_dp
  import uart_regfront_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] txIn,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txPop,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] txByte,
  output logic              txEmpty,
  output logic              txOverrun
);
  logic [DATA_W-1:0] rxHold, rxLast, txHold, rxHead, txHead;
  logic              txValid, rxEmpty, rxFull, txFifoEmpty, txFull;

  uart_regfront_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .push(strobe.fifoEn && rxPush), .din(rxByte),
    .pop(strobe.fifoEn && strobe.rxPop),
    .head(rxHead), .empty(rxEmpty), .full(rxFull));

  uart_regfront_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) txFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .push(strobe.fifoEn && strobe.txPush), .din(txIn),
    .pop(strobe.fifoEn && txPop),
    .head(txHead), .empty(txFifoEmpty), .full(txFull));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold    <= '0;
      rxLast    <= '0;
      txHold    <= '0;
      txValid   <= 1'b0;
      txOverrun <= 1'b0;
    end else begin
      if (!strobe.fifoEn && rxPush) rxHold <= rxByte;
      if (strobe.fifoEn && strobe.rxPop && !rxEmpty) rxLast <= rxHead;
      if (strobe.flush) begin
        txValid   <= 1'b0;
        txOverrun <= 1'b0;
      end else if (!strobe.fifoEn) begin
        if (strobe.txPush) begin
          txHold  <= txIn;
          txValid <= 1'b1;
        end else if (txPop) begin
          txValid <= 1'b0;
        end
      end else if (strobe.txPush && txFull) begin
        txOverrun <= 1'b1;
      end
    end
  end

  assign rxData  = strobe.fifoEn ? (rxEmpty ? rxLast : rxHead) : rxHold;
  assign txByte  = strobe.fifoEn ? txHead : txHold;
  assign txEmpty = strobe.fifoEn ? txFifoEmpty : !txValid;

  p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txOverrun && !strobe.flush) |=> txOverrun);
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> !txOverrun && txEmpty);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [1:0]        cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic              dmaRdAck,
  input  logic              dmaWrAck,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txPop,
  output logic [DATA_W-1:0] txByte,
  output logic              txEmpty,
  output logic              txOverrun,
  input  logic [DATA_W-1:0] irqSrc,
  output logic              irqOut
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] rxData;

  uart_regfront_ctrl #(.DATA_W(DATA_W)) ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .dmaRdAck(dmaRdAck),
    .dmaWrAck(dmaWrAck), .irqSrc(irqSrc), .rxData(rxData),
    .cpuRdata(cpuRdata), .irqOut(irqOut), .strobe(strobe));

  uart_regfront_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txIn(cpuWdata),
    .rxPush(rxPush), .rxByte(rxByte), .txPop(txPop),
    .rxData(rxData), .txByte(txByte), .txEmpty(txEmpty),
    .txOverrun(txOverrun));
endmodule

// File: tb/uart_regfront_test.sv
`timescale 1ns/1ps
module uart_regfront_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuSel = 0, cpuWr = 0, dmaRdAck = 0, dmaWrAck = 0;
  logic       rxPush = 0, txPop = 0;
  logic [1:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0, rxByte = '0, irqSrc = '0;
  logic [7:0] cpuRdata, txByte;
  logic       txEmpty, txOverrun, irqOut;
  int         checks = 0, failures = 0;
  bit         done = 0;
  logic [7:0] rd;

  always #2 clk = ~clk;

  uart_regfront uut (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .dmaRdAck(dmaRdAck),
    .dmaWrAck(dmaWrAck), .rxPush(rxPush), .rxByte(rxByte), .txPop(txPop),
    .txByte(txByte), .txEmpty(txEmpty), .txOverrun(txOverrun),
    .irqSrc(irqSrc), .irqOut(irqOut));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [1:0] a, input logic [7:0] d,
                      output logic [7:0] r);
    @(negedge clk);
    cpuSel = 1; cpuWr = wr; cpuAddr = a; cpuWdata = d;
    #1 r = cpuRdata;
    @(posedge clk);
    #1 cpuSel = 0; cpuWr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] unused;
    xfer(1'b1, a, d, unused);
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] r;
    xfer(1'b0, a, 8'h00, r);
    chk(tag, r, exp);
  endtask

  task automatic pushRx(input logic [7:0] b);
    @(negedge clk); rxPush = 1; rxByte = b;
    @(posedge clk); #1 rxPush = 0;
  endtask

  task automatic popTx;
    @(negedge clk); txPop = 1;
    @(posedge clk); #1 txPop = 0;
  endtask

  task automatic setMode(input logic [7:0] m);
    wr(2'd3, 8'd1); wr(2'd2, m); wr(2'd3, 8'd0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    chk("R1 irqOut", {7'b0, irqOut}, 8'h00);
    chk("R1 txEmpty", {7'b0, txEmpty}, 8'h01);
    chk("R1 txOverrun", {7'b0, txOverrun}, 8'h00);
    rdChk(2'd3, 8'h00, "R1 bank");
    rdChk(2'd1, 8'h00, "R1 ien");
    wr(2'd3, 8'd1); rdChk(2'd2, 8'h00, "R1 mode"); wr(2'd3, 8'd0);

    // R2 holding registers
    pushRx(8'h5A);
    rdChk(2'd0, 8'h5A, "R2 rx hold");
    pushRx(8'hC3);
    rdChk(2'd0, 8'hC3, "R2 rx hold overwrite");
    wr(2'd0, 8'h3C);
    chk("R2 txByte", txByte, 8'h3C);
    chk("R2 txEmpty low", {7'b0, txEmpty}, 8'h00);
    popTx;
    chk("R2 txEmpty after pop", {7'b0, txEmpty}, 8'h01);

    // R9 mode readback, R3 FIFOs
    setMode(8'h01);
    wr(2'd3, 8'd1); rdChk(2'd2, 8'h01, "R9 mode readback"); wr(2'd3, 8'd0);
    pushRx(8'h10); pushRx(8'h11); pushRx(8'h12);
    rdChk(2'd0, 8'h10, "R3 rx order 0");
    rdChk(2'd0, 8'h11, "R3 rx order 1");
    rdChk(2'd0, 8'h12, "R3 rx order 2");
    rdChk(2'd0, 8'h12, "R3 rx empty last");
    for (int i = 0; i < 16; i++) wr(2'd0, 8'h80 + 8'(i));
    chk("R3 no overrun at full", {7'b0, txOverrun}, 8'h00);
    wr(2'd0, 8'hEE);
    chk("R3 overrun set", {7'b0, txOverrun}, 8'h01);
    for (int i = 0; i < 16; i++) begin
      chk("R3 tx order", txByte, 8'h80 + 8'(i));
      popTx;
    end
    chk("R3 tx drained", {7'b0, txEmpty}, 8'h01);

    // R4 bank gating, R5 DMA
    pushRx(8'h21); pushRx(8'h22);
    wr(2'd3, 8'd2);
    rdChk(2'd3, 8'h02, "R4 bank readback");
    rdChk(2'd0, 8'h00, "R4 data hidden");
    wr(2'd0, 8'h77);
    chk("R4 write ignored", {7'b0, txEmpty}, 8'h01);
    wr(2'd1, 8'h0F);
    @(negedge clk); dmaRdAck = 1;
    #1 chk("R5 dma read", cpuRdata, 8'h21);
    @(posedge clk); #1 dmaRdAck = 0;
    @(negedge clk); dmaWrAck = 1; cpuWdata = 8'h55;
    @(posedge clk); #1 dmaWrAck = 0;
    chk("R5 dma write", txByte, 8'h55);
    wr(2'd3, 8'd0);
    rdChk(2'd0, 8'h22, "R4 no pop outside bank0");
    rdChk(2'd1, 8'h00, "R4 ien write ignored");

    // R9 flush
    pushRx(8'h33);
    setMode(8'h03);
    chk("R9 overrun cleared", {7'b0, txOverrun}, 8'h00);
    chk("R9 tx flushed", {7'b0, txEmpty}, 8'h01);
    rdChk(2'd0, 8'h22, "R9 rx flushed");

    // R7 / R6 mode-dependent enables
    wr(2'd1, 8'hFF);
    rdChk(2'd1, 8'hFF, "R7 ext all bits");
    setMode(8'h01);
    rdChk(2'd1, 8'h0F, "R7 upper cleared on non-ext");
    wr(2'd1, 8'hF3);
    rdChk(2'd1, 8'h03, "R6 upper masked");

    // R8 interrupt combine sweep in extended mode
    setMode(8'h02);
    for (int e = 0; e < 5; e++) begin
      logic [7:0] en;
      en = (e == 0) ? 8'h00 : (e == 1) ? 8'h0F : (e == 2) ? 8'hF0 : (e == 3) ? 8'hA5 : 8'hFF;
      wr(2'd1, en);
      for (int s = 0; s < 256; s++) begin
        irqSrc = 8'(s);
        #1 chk("R8 irq combine", {7'b0, irqOut}, {7'b0, |(en & 8'(s))});
      end
    end
    wr(2'd1, 8'h01); irqSrc = 8'h01;
    #1 chk("R8 irq asserted", {7'b0, irqOut}, 8'h01);
    wr(2'd1, 8'h00);
    chk("R8 irq cleared by enable", {7'b0, irqOut}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule